// File: doc/BRIEF.md
# Multiprocessor Wake-Up Serial Receiver

This block receives asynchronous serial frames on a single line. The line is oversampled by a 16x strobe that a separate baud generator supplies. A frame is a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and one or more high stop bits. The received character is placed in a 9-bit receive buffer. A one-cycle receive pulse signals each new character. A parity-error pulse and a framing-error pulse flag bad frames.

The ninth bit can be used in three ways, chosen by a static mode input: as plain data, as a parity bit, or as an address marker. The address-marker mode lets several receivers share one line. Each receiver stays in address-marker mode and sees only frames whose ninth bit is 1 (addresses). Frames whose ninth bit is 0 (data) are discarded with no buffer write and no pulse. The receiver that recognises its address switches to plain nine-bit mode, so it also takes the following data frames. The other receivers keep ignoring them.

A falling edge on the idle line starts a frame. The start bit is confirmed by a sample near its centre, and every later bit is sampled once per bit period at the same phase.

Top module: `mpwu_uart_rx`

## Requirements
- R1: After reset, rx_buf is 0 and rx_irq, perr_irq and ferr_irq are low.
- R2: With mode_sel = 2'b00 (eight-bit mode) a frame carries eight data bits. The first data bit after the start bit lands in rx_buf[0], the last in rx_buf[7], and rx_buf[8] is written as 0.
- R3: With mode_sel = 2'b01 (nine-bit data mode) the bit that follows the eight data bits is stored in rx_buf[8], and the frame is accepted whatever its value.
- R4: With mode_sel = 2'b10 (parity mode) the received parity bit is stored in rx_buf[8], and the frame is written even when the parity is wrong.
- R5: In parity mode with odd_par = 0, a frame whose eight data bits plus parity bit hold an odd number of ones raises perr_irq in the same cycle as rx_irq. A frame with an even count raises no perr_irq.
- R6: With odd_par = 1 the parity sense is inverted: an even count of ones over data plus parity raises perr_irq.
- R7: With mode_sel = 2'b11 (address-marker mode), a frame whose ninth bit is 0 leaves rx_buf unchanged and raises no rx_irq.
- R8: In address-marker mode, a frame whose ninth bit is 1 is written, with rx_buf[8] = 1. After a change to nine-bit data mode, a following frame with ninth bit 0 is written.
- R9: If any of the STOP_BITS stop bits is sampled low, ferr_irq pulses for one cycle, rx_buf is unchanged and no rx_irq is raised.
- R10: rx_irq is high for exactly one clock cycle, in the cycle after rx_buf is written.
- R11: While rx_en is low the line is ignored: no frame is started, sampled or written.
- R12: The start bit is confirmed by a sample taken 8 oversample strobes after the falling edge. A low pulse shorter than that produces no frame and no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_en | input | 1 | Receiver enable |
| mode_sel | input | 2 | Frame mode: 00 eight-bit, 01 nine-bit data, 10 parity, 11 address marker |
| odd_par | input | 1 | 1 selects odd parity, 0 even |
| rxd | input | 1 | Serial receive line, idle high |
| rx_buf | output | 9 | Receive buffer |
| rx_irq | output | 1 | Receive pulse, one cycle |
| perr_irq | output | 1 | Parity-error pulse |
| ferr_irq | output | 1 | Framing-error pulse |

## Verification
The bench builds the receiver with STOP_BITS = 2, OVERSAMPLE = 16 and two synchroniser stages. The oversample strobe fires on every second clock. With two stop bits, a frame can be made with a good first stop bit and a low second one, so the check of the last stop bit is exercised separately from the first. The slow strobe also leaves room to send a start glitch that ends before the centre sample.

// File: rtl/mpwu_rx_pkg.sv
package mpwu_rx_pkg;

  typedef enum logic [1:0] {
    MODE_D8   = 2'b00,
    MODE_D9   = 2'b01,
    MODE_PAR  = 2'b10,
    MODE_WAKE = 2'b11
  } rx_mode_e;

  localparam int DATA_W = 8;

  // number of payload bits (data plus optional ninth bit) for a mode
  function automatic int payload_bits(rx_mode_e m);
    return (m == MODE_D8) ? DATA_W : DATA_W + 1;
  endfunction

  // bits sampled after the start bit: payload plus stop bits
  function automatic int frame_bits(rx_mode_e m, int stops);
    return payload_bits(m) + stops;
  endfunction

  // 1 when data plus parity bit disagree with the selected sense
  function automatic logic parity_bad(logic [DATA_W-1:0] d, logic p, logic odd);
    return (^d) ^ p ^ odd;
  endfunction

  // address-marker mode keeps only frames with the ninth bit set
  function automatic logic frame_wanted(rx_mode_e m, logic b9);
    return (m != MODE_WAKE) || b9;
  endfunction

endpackage

// File: rtl/mpwu_rx_sync.sv
module mpwu_rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RESET_VAL;
        else        pipe[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RESET_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mpwu_rx_timer.sv
module mpwu_rx_timer #(
  parameter int OVS = 16,
  parameter int BW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          line,
  input  logic [BW-1:0] frame_len,
  output logic          start_det,
  output logic          start_ok,
  output logic          bit_stb,
  output logic          frame_done,
  output logic [BW-1:0] bit_idx
);
  localparam int CW  = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int MID = OVS / 2;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS} tstate_e;

  tstate_e       st;
  logic [CW-1:0] cnt;
  logic          line_q;
  logic          mid_hit;

  assign mid_hit    = tick && (cnt == CW'(MID - 1));
  assign start_det  = en && (st == ST_IDLE) && tick && line_q && !line;
  assign start_ok   = en && (st == ST_START) && mid_hit && !line;
  assign bit_stb    = en && (st == ST_BITS) && mid_hit;
  assign frame_done = bit_stb && (bit_idx == frame_len - BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      line_q  <= 1'b0;
      bit_idx <= '0;
    end else begin
      if (tick) line_q <= line;

      if (start_det)
        cnt <= '0;
      else if (st != ST_IDLE && tick)
        cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + CW'(1);

      if (!en) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE:  if (start_det) st <= ST_START;
          ST_START: if (mid_hit) begin
                      st      <= line ? ST_IDLE : ST_BITS;
                      bit_idx <= '0;
                    end
          ST_BITS:  if (bit_stb) begin
                      bit_idx <= bit_idx + BW'(1);
                      if (frame_done) st <= ST_IDLE;
                    end
          default:  st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpwu_rx_decode.sv
module mpwu_rx_decode
  import mpwu_rx_pkg::*;
#(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rx_mode_e      mode,
  input  logic          odd_par,
  input  logic          line,
  input  logic          start_ok,
  input  logic          bit_stb,
  input  logic          frame_done,
  input  logic [BW-1:0] bit_idx,
  output logic [DATA_W:0] rx_buf,
  output logic          rx_irq,
  output logic          perr_irq,
  output logic          ferr_irq,
  output logic          buf_we,
  output logic          stop_ok,
  output logic          frame_b9
);
  logic [DATA_W:0] pay;
  logic            stop_bad;
  logic [BW-1:0]   n_pay;
  logic            wanted;

  assign n_pay    = BW'(payload_bits(mode));
  assign frame_b9 = pay[DATA_W];
  assign stop_ok  = !stop_bad && line;
  assign wanted   = frame_wanted(mode, frame_b9);
  assign buf_we   = frame_done && stop_ok && wanted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay      <= '0;
      stop_bad <= 1'b0;
    end else if (start_ok) begin
      pay      <= '0;
      stop_bad <= 1'b0;
    end else if (bit_stb) begin
      if (bit_idx < n_pay) begin
        for (int i = 0; i <= DATA_W; i++)
          if (bit_idx == BW'(i)) pay[i] <= line;
      end else if (!line) begin
        stop_bad <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf   <= '0;
      rx_irq   <= 1'b0;
      perr_irq <= 1'b0;
      ferr_irq <= 1'b0;
    end else begin
      if (buf_we) rx_buf <= pay;
      rx_irq   <= buf_we;
      perr_irq <= buf_we && (mode == MODE_PAR) &&
                  parity_bad(pay[DATA_W-1:0], pay[DATA_W], odd_par);
      ferr_irq <= frame_done && !stop_ok;
    end
  end
endmodule

// File: rtl/mpwu_uart_rx.sv
module mpwu_uart_rx
  import mpwu_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int STOP_BITS   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_en,
  input  logic [1:0] mode_sel,
  input  logic       odd_par,
  input  logic       rxd,
  output logic [8:0] rx_buf,
  output logic       rx_irq,
  output logic       perr_irq,
  output logic       ferr_irq
);
  localparam int MAX_BITS = DATA_W + 1 + STOP_BITS;
  localparam int BW       = $clog2(MAX_BITS + 1);

  rx_mode_e      mode;
  logic          line;
  logic [BW-1:0] frame_len;
  logic          start_det, start_ok, bit_stb, frame_done;
  logic [BW-1:0] bit_idx;
  logic          buf_we, stop_ok, frame_b9;

  assign mode      = rx_mode_e'(mode_sel);
  assign frame_len = BW'(frame_bits(mode, STOP_BITS));

  mpwu_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line)
  );

  mpwu_rx_timer #(.OVS(OVERSAMPLE), .BW(BW)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .line(line),
    .frame_len(frame_len), .start_det(start_det), .start_ok(start_ok),
    .bit_stb(bit_stb), .frame_done(frame_done), .bit_idx(bit_idx)
  );

  mpwu_rx_decode #(.BW(BW)) u_decode (
    .clk(clk), .rst_n(rst_n), .mode(mode), .odd_par(odd_par), .line(line),
    .start_ok(start_ok), .bit_stb(bit_stb), .frame_done(frame_done),
    .bit_idx(bit_idx), .rx_buf(rx_buf), .rx_irq(rx_irq),
    .perr_irq(perr_irq), .ferr_irq(ferr_irq), .buf_we(buf_we),
    .stop_ok(stop_ok), .frame_b9(frame_b9)
  );
endmodule

// File: rtl/mpwu_uart_rx_checker.sv
module mpwu_uart_rx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic [1:0] mode_sel,
  input logic [8:0] rx_buf,
  input logic       rx_irq,
  input logic       perr_irq,
  input logic       ferr_irq,
  input logic       buf_we,
  input logic       frame_done,
  input logic       stop_ok,
  input logic       frame_b9,
  input logic       bit_stb,
  input logic       start_ok
);
  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  p_irq_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> rx_irq);

  p_buf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_we |=> $stable(rx_buf));

  p_wake_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mode_sel == 2'b11 && !frame_b9) |-> !buf_we);

  p_wake_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && stop_ok && mode_sel == 2'b11 && frame_b9) |-> buf_we);

  p_d9_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && stop_ok && mode_sel == 2'b01) |-> buf_we);

  p_ferr_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !stop_ok) |=> (ferr_irq && !rx_irq));

  p_perr_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    perr_irq |-> (rx_irq && mode_sel == 2'b10));

  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (!bit_stb && !start_ok));
endmodule

bind mpwu_uart_rx mpwu_uart_rx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode_sel(mode_sel),
  .rx_buf(rx_buf), .rx_irq(rx_irq), .perr_irq(perr_irq), .ferr_irq(ferr_irq),
  .buf_we(buf_we), .frame_done(frame_done), .stop_ok(stop_ok),
  .frame_b9(frame_b9), .bit_stb(bit_stb), .start_ok(start_ok)
);

// File: tb/test_mpwu_uart_rx.sv
module test_mpwu_uart_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_en = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       odd_par = 1'b0;
  logic       rxd = 1'b1;
  logic [8:0] rx_buf;
  logic       rx_irq, perr_irq, ferr_irq;

  int checks = 0, errors = 0;
  int irq_cnt = 0, perr_cnt = 0, ferr_cnt = 0;
  bit done = 1'b0;

  mpwu_uart_rx #(.OVERSAMPLE(16), .STOP_BITS(2), .SYNC_STAGES(2)) i_mpwu_uart_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en),
    .mode_sel(mode_sel), .odd_par(odd_par), .rxd(rxd), .rx_buf(rx_buf),
    .rx_irq(rx_irq), .perr_irq(perr_irq), .ferr_irq(ferr_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(negedge clk) tick16 <= ~tick16;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_irq)   irq_cnt++;
      if (perr_irq) perr_cnt++;
      if (ferr_irq) ferr_cnt++;
    end
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  // start bit, 8 data LSB first, optional ninth, two stop bits, idle gap
  task automatic send(input logic [7:0] d, input logic has9, input logic b9, input logic s2);
    hold_line(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) hold_line(d[i], BIT_CLKS);
    if (has9) hold_line(b9, BIT_CLKS);
    hold_line(1'b1, BIT_CLKS);
    hold_line(s2, BIT_CLKS);
    hold_line(1'b1, 2 * BIT_CLKS);
  endtask

  task automatic frame_test(input string req, input logic [1:0] m, input logic odd,
                            input logic [7:0] d, input logic b9, input logic s2,
                            input int e_irq, input int e_perr, input int e_ferr,
                            input logic [8:0] e_buf);
    int i0 = irq_cnt, p0 = perr_cnt, f0 = ferr_cnt;
    mode_sel = m;
    odd_par  = odd;
    send(d, m != 2'b00, b9, s2);
    check_eq(req, "rx_irq cycles", irq_cnt - i0, e_irq);
    check_eq(req, "perr_irq cycles", perr_cnt - p0, e_perr);
    check_eq(req, "ferr_irq cycles", ferr_cnt - f0, e_ferr);
    check_eq(req, "rx_buf", int'(rx_buf), int'(e_buf));
  endtask

  function automatic logic even_bit(input logic [7:0] d);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(d[i]);
    return (n % 2) == 1;
  endfunction

  task automatic t_reset;
    check_eq("R1", "rx_buf", int'(rx_buf), 0);
    check_eq("R1", "pulses", int'({rx_irq, perr_irq, ferr_irq}), 0);
  endtask

  task automatic t_eight_bit;
    frame_test("R2", 2'b00, 1'b0, 8'hA5, 1'b0, 1'b1, 1, 0, 0, 9'h0A5);
    frame_test("R2", 2'b00, 1'b0, 8'h01, 1'b0, 1'b1, 1, 0, 0, 9'h001);
  endtask

  task automatic t_nine_bit;
    frame_test("R3", 2'b01, 1'b0, 8'h3C, 1'b1, 1'b1, 1, 0, 0, 9'h13C);
    frame_test("R3", 2'b01, 1'b0, 8'hC3, 1'b0, 1'b1, 1, 0, 0, 9'h0C3);
  endtask

  task automatic t_parity;
    logic p = even_bit(8'h3C);
    frame_test("R4", 2'b10, 1'b0, 8'h3C, p, 1'b1, 1, 0, 0, {p, 8'h3C});
    frame_test("R5", 2'b10, 1'b0, 8'h3C, ~p, 1'b1, 1, 1, 0, {~p, 8'h3C});
    p = ~even_bit(8'h07);
    frame_test("R6", 2'b10, 1'b1, 8'h07, p, 1'b1, 1, 0, 0, {p, 8'h07});
    frame_test("R6", 2'b10, 1'b1, 8'h07, ~p, 1'b1, 1, 1, 0, {~p, 8'h07});
  endtask

  task automatic t_wake;
    frame_test("R8", 2'b11, 1'b0, 8'h42, 1'b1, 1'b1, 1, 0, 0, 9'h142);
    frame_test("R7", 2'b11, 1'b0, 8'h99, 1'b0, 1'b1, 0, 0, 0, 9'h142);
    frame_test("R8", 2'b01, 1'b0, 8'h99, 1'b0, 1'b1, 1, 0, 0, 9'h099);
  endtask

  task automatic t_framing;
    frame_test("R9", 2'b00, 1'b0, 8'h5A, 1'b0, 1'b0, 0, 0, 1, 9'h099);
  endtask

  task automatic t_glitch;
    int i0 = irq_cnt, f0 = ferr_cnt;
    hold_line(1'b0, 3 * TICK_DIV);
    hold_line(1'b1, 3 * BIT_CLKS);
    check_eq("R12", "rx_irq cycles", irq_cnt - i0, 0);
    check_eq("R12", "ferr_irq cycles", ferr_cnt - f0, 0);
    frame_test("R12", 2'b00, 1'b0, 8'h81, 1'b0, 1'b1, 1, 0, 0, 9'h081);
  endtask

  task automatic t_disabled;
    rx_en = 1'b0;
    frame_test("R11", 2'b00, 1'b0, 8'hEE, 1'b0, 1'b1, 0, 0, 0, 9'h081);
    rx_en = 1'b1;
    hold_line(1'b1, BIT_CLKS);
    frame_test("R11", 2'b00, 1'b0, 8'h18, 1'b0, 1'b1, 1, 0, 0, 9'h018);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    t_eight_bit();   // R10 checked by single-cycle rx_irq counts throughout
    t_nine_bit();
    t_parity();
    t_wake();
    t_framing();
    t_glitch();
    t_disabled();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule